// File: doc/BRIEF.md
# Direct-Mapped Instruction Cache

This block sits between a processor's fetch stage and a pipelined 32-bit read port on the memory fabric. The fetch stage presents a byte address with a request strobe. When the addressed line is resident, the word comes back in the same cycle with an acknowledge. When the line is missing, the fetch is stalled. The cache then reads the whole 32-byte line from memory and serves the held fetch from the newly filled line.

The line fill is pipelined. One read request goes out per clock, without waiting for data from earlier requests, unless the memory holds the request with its stall input. Returned words are accepted only on the data-valid strobe. They arrive in issue order and are written to successive word slots of the line. The fill engine therefore counts issued beats and returned beats separately.

A whole-cache invalidate input clears every valid bit at once. It also overrides a fill in progress. That fill still drains its outstanding reads on the bus, but it does not mark its line valid.

Top module: `icache_direct`

## Requirements
- R1: The fetch address divides into tag bits [31:12], line index bits [11:5] and word select bits [4:2] over 128 lines of eight 32-bit words; bits [1:0] have no effect on the returned word (little-endian full word at the aligned address).
- R2: When the indexed line is valid and its tag matches, `fe_ack` rises in the same cycle as `fe_req` with `fe_rdata` equal to the memory word, and `fe_stall` equals `fe_req` and not `fe_ack`.
- R3: A miss starts a line fill that reads the eight words of the missed line at line base plus 4*k, k ascending from 0 to 7; exactly one fill occurs per miss.
- R4: After a read is accepted that is not the eighth of its fill, `mem_read` is high in the next cycle, whatever data has or has not returned.
- R5: While `mem_read` and `mem_wait` are both high, the request and its address are held unchanged into the next cycle.
- R6: Returned data is taken only in cycles where `mem_rvalid` is high, and the n-th returned beat of a fill lands in word n of the line, for any return latency.
- R7: The line becomes valid only after its eighth word is written; no fetch is acknowledged while a fill is in progress; afterwards the stalled fetch is served from the filled line.
- R8: A one-cycle `inval` pulse clears all valid bits, so the next fetch to any previously resident line misses.
- R9: An `inval` during a fill lets the fill finish its eight reads and returns but leaves the line invalid, so the still-pending fetch triggers a second fill.
- R10: After reset no line is valid, `mem_read` is low and, with no request, `fe_stall` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| inval | input | 1 | Clear all valid bits |
| fe_req | input | 1 | Fetch request, held until acknowledged |
| fe_addr | input | 32 | Fetch byte address |
| fe_ack | output | 1 | Fetch served this cycle |
| fe_rdata | output | 32 | Fetched instruction word |
| fe_stall | output | 1 | Fetch pending and not served |
| mem_read | output | 1 | Memory read request |
| mem_addr | output | 32 | Memory read byte address (word aligned) |
| mem_wait | input | 1 | Memory stall, request must be held |
| mem_rdata | input | 32 | Memory read data |
| mem_rvalid | input | 1 | Memory read data valid |

## Verification
The bench goes after the pipelined fill under random stall and random return latency. A design that waits for data before issuing the next read shows a fill span longer than seven cycles with the stall disabled. A design that counts returns against issues wrongly loads words into the wrong slots and returns bad instructions. Aliasing lines that share an index but differ in tag, and byte offsets in the low address bits, expose faulty compare or word-select decoding as wrong data or missing refills. An invalidate pulse in the middle of a fill catches a design that still marks the line valid: it shows up as a single fill where two are expected. A design that aborts the fill without draining it shows up as out-of-order beats at the memory port.

// File: rtl/icache_pkg.sv
package icache_pkg;
   typedef enum logic [0:0] {
      FS_IDLE = 1'b0,
      FS_FILL = 1'b1
   } fill_state_e;
endpackage

// File: rtl/icache_tag_store.sv
module icache_tag_store #(
   parameter int NUM_LINES = 128,
   parameter int IDX_W     = 7,
   parameter int TAG_W     = 20
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inv_all,
   input  logic             clr_en,
   input  logic [IDX_W-1:0] clr_idx,
   input  logic             set_en,
   input  logic [IDX_W-1:0] set_idx,
   input  logic [TAG_W-1:0] set_tag,
   input  logic [IDX_W-1:0] rd_idx,
   input  logic [TAG_W-1:0] rd_tag,
   output logic             hit
);
   logic [NUM_LINES-1:0] vld;
   logic [TAG_W-1:0]     tags [NUM_LINES];

   initial begin
      assert (NUM_LINES == (1 << IDX_W))
         else $error("tag store: line count must equal 2**IDX_W");
   end

   for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
      logic v_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            v_q <= 1'b0;
         else if (inv_all)
            v_q <= 1'b0;
         else if (set_en && set_idx == IDX_W'(i))
            v_q <= 1'b1;
         else if (clr_en && clr_idx == IDX_W'(i))
            v_q <= 1'b0;
      end
      assign vld[i] = v_q;
   end

   always_ff @(posedge clk) begin
      if (set_en)
         tags[set_idx] <= set_tag;
   end

   assign hit = vld[rd_idx] && (tags[rd_idx] == rd_tag);

   // R8: invalidate leaves no valid line behind
   p_inval_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
      inv_all |=> (vld == '0));

   // R7: a completed fill makes its line valid
   p_fill_sets_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (set_en && !inv_all) |=> vld[$past(set_idx)]);
endmodule

// File: rtl/icache_data_store.sv
module icache_data_store #(
   parameter int NUM_LINES = 128,
   parameter int WORDS     = 8,
   parameter int DATA_W    = 32,
   parameter int IDX_W     = 7,
   parameter int WSEL_W    = 3
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [WSEL_W-1:0] wr_sel,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [IDX_W-1:0]  rd_idx,
   input  logic [WSEL_W-1:0] rd_sel,
   output logic [DATA_W-1:0] rd_data
);
   localparam int DEPTH = NUM_LINES * WORDS;

   logic [DATA_W-1:0] mem [DEPTH];

   initial begin
      assert (WORDS == (1 << WSEL_W))
         else $error("data store: words per line must equal 2**WSEL_W");
   end

   always_ff @(posedge clk) begin
      if (wr_en)
         mem[{wr_idx, wr_sel}] <= wr_data;
   end

   assign rd_data = mem[{rd_idx, rd_sel}];
endmodule

// File: rtl/icache_fill_ctrl.sv
module icache_fill_ctrl
   import icache_pkg::*;
#(
   parameter int WORDS  = 8,
   parameter int WSEL_W = 3,
   parameter int IDX_W  = 7,
   parameter int TAG_W  = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              inv_all,
   input  logic              miss,
   input  logic [TAG_W-1:0]  req_tag,
   input  logic [IDX_W-1:0]  req_idx,
   input  logic              m_wait,
   input  logic              m_rvalid,
   output logic              m_read,
   output logic [TAG_W-1:0]  m_tag,
   output logic [IDX_W-1:0]  m_idx,
   output logic [WSEL_W-1:0] m_sel,
   output logic              busy,
   output logic              wr_en,
   output logic [WSEL_W-1:0] wr_sel,
   output logic              clr_en,
   output logic              set_en
);
   localparam int CNT_W = WSEL_W + 1;
   localparam logic [CNT_W-1:0] BEATS_C = CNT_W'(WORDS);
   localparam logic [CNT_W-1:0] LAST_C  = CNT_W'(WORDS - 1);

   fill_state_e      state_q;
   logic [CNT_W-1:0] iss_q, ret_q;
   logic             kill_q;
   logic [TAG_W-1:0] tag_q;
   logic [IDX_W-1:0] idx_q;

   logic start, iss_fire, ret_fire, last_ret;

   assign busy     = (state_q == FS_FILL);
   assign start    = (state_q == FS_IDLE) && miss;
   assign m_read   = busy && (iss_q < BEATS_C);
   assign iss_fire = m_read && !m_wait;
   assign ret_fire = busy && m_rvalid;
   assign last_ret = ret_fire && (ret_q == LAST_C);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= FS_IDLE;
         iss_q   <= '0;
         ret_q   <= '0;
         kill_q  <= 1'b0;
         tag_q   <= '0;
         idx_q   <= '0;
      end else if (start) begin
         state_q <= FS_FILL;
         iss_q   <= '0;
         ret_q   <= '0;
         kill_q  <= 1'b0;
         tag_q   <= req_tag;
         idx_q   <= req_idx;
      end else if (busy) begin
         if (iss_fire)
            iss_q <= iss_q + 1'b1;
         if (ret_fire)
            ret_q <= ret_q + 1'b1;
         if (inv_all)
            kill_q <= 1'b1;
         if (last_ret)
            state_q <= FS_IDLE;
      end
   end

   assign m_tag  = tag_q;
   assign m_idx  = idx_q;
   assign m_sel  = iss_q[WSEL_W-1:0];
   assign wr_en  = ret_fire;
   assign wr_sel = ret_q[WSEL_W-1:0];
   assign clr_en = start;
   assign set_en = last_ret && !kill_q && !inv_all;

   // R4: reads go out back to back until the line is requested
   p_back_to_back_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_fire && iss_q < LAST_C) |=> m_read);

   // R5: a stalled request keeps its address
   p_hold_on_wait_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (m_read && m_wait) |=> (m_read && $stable(m_sel) && $stable(m_idx) && $stable(m_tag)));

   // R6: returns never overtake issues
   p_ret_le_iss_r6: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (ret_q <= iss_q));
endmodule

// File: rtl/icache_direct.sv
module icache_direct #(
   parameter int ADDR_W     = 32,
   parameter int DATA_W     = 32,
   parameter int LINE_BYTES = 32,
   parameter int NUM_LINES  = 128
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              inval,
   input  logic              fe_req,
   input  logic [ADDR_W-1:0] fe_addr,
   output logic              fe_ack,
   output logic [DATA_W-1:0] fe_rdata,
   output logic              fe_stall,
   output logic              mem_read,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic              mem_wait,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic              mem_rvalid
);
   localparam int BYTE_W = $clog2(DATA_W / 8);
   localparam int WORDS  = LINE_BYTES / (DATA_W / 8);
   localparam int WSEL_W = $clog2(WORDS);
   localparam int OFF_W  = BYTE_W + WSEL_W;
   localparam int IDX_W  = $clog2(NUM_LINES);
   localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;

   initial begin
      assert (DATA_W % 8 == 0 && (DATA_W / 8) == (1 << BYTE_W))
         else $error("icache: word width must be a power-of-two byte count");
      assert (WORDS >= 2 && WORDS == (1 << WSEL_W))
         else $error("icache: line must hold a power-of-two count of at least two words");
      assert (NUM_LINES >= 2 && NUM_LINES == (1 << IDX_W))
         else $error("icache: line count must be a power of two");
      assert (TAG_W >= 1)
         else $error("icache: address too narrow for this geometry");
   end

   logic [TAG_W-1:0]  req_tag;
   logic [IDX_W-1:0]  req_idx;
   logic [WSEL_W-1:0] req_sel;

   assign req_tag = fe_addr[ADDR_W-1 -: TAG_W];
   assign req_idx = fe_addr[OFF_W +: IDX_W];
   assign req_sel = fe_addr[BYTE_W +: WSEL_W];

   logic              hit, miss, busy;
   logic [TAG_W-1:0]  m_tag;
   logic [IDX_W-1:0]  m_idx;
   logic [WSEL_W-1:0] m_sel, wr_sel;
   logic              wr_en, clr_en, set_en;

   icache_tag_store #(
      .NUM_LINES (NUM_LINES),
      .IDX_W     (IDX_W),
      .TAG_W     (TAG_W)
   ) tags_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .inv_all (inval),
      .clr_en  (clr_en),
      .clr_idx (req_idx),
      .set_en  (set_en),
      .set_idx (m_idx),
      .set_tag (m_tag),
      .rd_idx  (req_idx),
      .rd_tag  (req_tag),
      .hit     (hit)
   );

   icache_data_store #(
      .NUM_LINES (NUM_LINES),
      .WORDS     (WORDS),
      .DATA_W    (DATA_W),
      .IDX_W     (IDX_W),
      .WSEL_W    (WSEL_W)
   ) data_i (
      .clk     (clk),
      .wr_en   (wr_en),
      .wr_idx  (m_idx),
      .wr_sel  (wr_sel),
      .wr_data (mem_rdata),
      .rd_idx  (req_idx),
      .rd_sel  (req_sel),
      .rd_data (fe_rdata)
   );

   icache_fill_ctrl #(
      .WORDS  (WORDS),
      .WSEL_W (WSEL_W),
      .IDX_W  (IDX_W),
      .TAG_W  (TAG_W)
   ) fill_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .inv_all  (inval),
      .miss     (miss),
      .req_tag  (req_tag),
      .req_idx  (req_idx),
      .m_wait   (mem_wait),
      .m_rvalid (mem_rvalid),
      .m_read   (mem_read),
      .m_tag    (m_tag),
      .m_idx    (m_idx),
      .m_sel    (m_sel),
      .busy     (busy),
      .wr_en    (wr_en),
      .wr_sel   (wr_sel),
      .clr_en   (clr_en),
      .set_en   (set_en)
   );

   assign miss     = fe_req && !hit;
   assign fe_ack   = fe_req && hit;
   assign fe_stall = fe_req && !hit;
   assign mem_addr = {m_tag, m_idx, m_sel, {BYTE_W{1'b0}}};

   // R7: a line being filled is never reported as a hit
   p_no_ack_in_fill_r7: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !fe_ack);

   // R10: idle cache with no request never reads memory
   p_quiet_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy) |-> !mem_read);
endmodule

// File: tb/icache_direct_tb_top.sv
`timescale 1ns/1ps
module icache_direct_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        inval = 1'b0;
   logic        fe_req = 1'b0;
   logic [31:0] fe_addr = '0;
   logic        fe_ack, fe_stall, mem_read;
   logic [31:0] fe_rdata, mem_addr;
   logic        mem_wait = 1'b0;
   logic [31:0] mem_rdata = '0;
   logic        mem_rvalid = 1'b0;

   always #5 clk = ~clk;

   icache_direct dut_i (
      .clk(clk), .rst_n(rst_n), .inval(inval),
      .fe_req(fe_req), .fe_addr(fe_addr), .fe_ack(fe_ack),
      .fe_rdata(fe_rdata), .fe_stall(fe_stall),
      .mem_read(mem_read), .mem_addr(mem_addr), .mem_wait(mem_wait),
      .mem_rdata(mem_rdata), .mem_rvalid(mem_rvalid)
   );

   int n_chk = 0, n_bad = 0;
   bit done = 0;

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] mem_word(input logic [31:0] a);
      logic [31:0] w;
      w = {a[31:2], 2'b00};
      return (w * 32'h0100_0193) ^ {w[15:0], w[31:16]} ^ 32'hC3A5_0F1E;
   endfunction

   // memory model: random stall, random in-order return latency
   bit          stall_en = 1;
   int          lat_max = 5;
   int          ncyc = 0;
   logic [31:0] q_addr [16];
   int          q_rdy [16];
   int          q_rd = 0, q_wr = 0, q_cnt = 0, last_rdy = 0;
   logic [2:0]  exp_beat = '0;
   int          fills = 0, first_cyc = 0, last_span = 0;
   bit          prev_hold = 0;
   logic [31:0] prev_addr = '0;

   always @(negedge clk) begin
      if (!rst_n) begin
         q_rd = 0; q_wr = 0; q_cnt = 0; exp_beat = '0; prev_hold = 0;
         mem_rvalid = 1'b0; mem_wait = 1'b0;
      end else begin
         if (q_cnt > 0 && q_rdy[q_rd] <= ncyc) begin
            mem_rvalid = 1'b1;
            mem_rdata  = mem_word(q_addr[q_rd]);
            q_rd = (q_rd + 1) % 16; q_cnt--;
         end else begin
            mem_rvalid = 1'b0;
            mem_rdata  = 32'hBAD0_0BAD;
         end
         mem_wait = stall_en ? ($urandom % 4 == 0) : 1'b0;
         if (prev_hold)
            chk(mem_read && mem_addr == prev_addr, "R5 held request", mem_addr, prev_addr);
         if (mem_read && !mem_wait) begin
            chk(mem_addr[4:2] == exp_beat && mem_addr[1:0] == 2'b00, "R3 beat order",
                {29'd0, mem_addr[4:2]}, {29'd0, exp_beat});
            if (exp_beat == 3'd0) begin fills++; first_cyc = ncyc; end
            if (exp_beat == 3'd7) last_span = ncyc - first_cyc;
            exp_beat = exp_beat + 3'd1;
            begin
               int r;
               r = ncyc + 1 + ($urandom % lat_max);
               if (r < last_rdy) r = last_rdy;
               last_rdy = r;
               q_addr[q_wr] = mem_addr; q_rdy[q_wr] = r;
               q_wr = (q_wr + 1) % 16; q_cnt++;
            end
         end
         prev_hold = mem_read && mem_wait;
         prev_addr = mem_addr;
         ncyc++;
      end
   end

   // reference tag model
   bit          ref_v [128];
   logic [19:0] ref_t [128];
   int          exp_fills = 0;

   task automatic do_fetch(input logic [31:0] a, output int waited);
      fe_req = 1'b1; fe_addr = a; #1;
      waited = 0;
      while (!fe_ack && waited < 2000) begin
         if (fe_stall !== 1'b1) chk(0, "R2 stall flag", {31'd0, fe_stall}, 32'd1);
         @(negedge clk); #1;
         waited++;
      end
      chk(fe_rdata == mem_word(a), "R6 R7 fetched word", fe_rdata, mem_word(a));
      @(negedge clk);
   endtask

   task automatic fetch_ref(input logic [31:0] a);
      int w;
      bit h;
      h = ref_v[a[11:5]] && ref_t[a[11:5]] == a[31:12];
      do_fetch(a, w);
      if (h) chk(w == 0, "R2 hit same cycle", w, 0);
      else begin
         chk(w > 0, "R1 R3 miss stalls", w, 1);
         exp_fills++;
         ref_v[a[11:5]] = 1; ref_t[a[11:5]] = a[31:12];
      end
   endtask

   task automatic ref_clear();
      for (int i = 0; i < 128; i++) ref_v[i] = 0;
   endtask

   initial begin
      ref_clear();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk); #1;
      // R10: reset state
      chk(mem_read == 1'b0, "R10 no read after reset", {31'd0, mem_read}, 32'd0);
      chk(fe_stall == 1'b0 && fe_ack == 1'b0, "R10 idle outputs", {30'd0, fe_stall, fe_ack}, 32'd0);
      fe_req = 1'b1; fe_addr = 32'h0000_0040; #1;
      chk(fe_ack == 1'b0, "R10 no valid line", {31'd0, fe_ack}, 32'd0);
      fe_req = 1'b0;
      @(negedge clk);

      // R1/R6 sweep: every word of 4 KB, varying byte offset, then again as hits
      for (int pass = 0; pass < 2; pass++)
         for (int i = 0; i < 1024; i++)
            fetch_ref(32'h0000_0000 + i * 4 + ((i + pass) % 4));
      // R1: alias lines with another tag, one word per line
      for (int i = 0; i < 128; i++)
         fetch_ref(32'h8010_0000 + i * 32 + (i % 8) * 4);
      for (int i = 0; i < 128; i++)
         fetch_ref(32'h8010_0000 + i * 32 + ((i + 3) % 8) * 4 + 2);
      fe_req = 1'b0;
      chk(fills == exp_fills, "R3 fill count", fills, exp_fills);

      // R4: back-to-back issue with no stall and one-cycle latency
      stall_en = 0; lat_max = 1;
      @(negedge clk);
      fetch_ref(32'h0000_3000);
      chk(last_span == 7, "R4 eight reads in eight cycles", last_span, 7);
      lat_max = 6;
      fetch_ref(32'h0000_4020);
      chk(last_span == 7, "R4 issue ignores slow returns", last_span, 7);
      stall_en = 1; lat_max = 5;

      // R8: invalidate while idle
      fe_req = 1'b0;
      @(negedge clk);
      inval = 1'b1; @(negedge clk); inval = 1'b0;
      ref_clear();
      begin
         int w;
         do_fetch(32'h0000_0104, w);
         chk(w > 0, "R8 miss after invalidate", w, 1);
         exp_fills++; ref_v[8] = 1; ref_t[8] = 20'h0;
      end
      fetch_ref(32'h0000_0108);

      // R9: invalidate during a fill
      begin
         int w, f0;
         f0 = fills;
         fork
            do_fetch(32'h0000_5060, w);
            begin
               repeat (3) @(negedge clk);
               inval = 1'b1; @(negedge clk); inval = 1'b0;
            end
         join
         chk(fills - f0 == 2, "R9 second fill after killed fill", fills - f0, 2);
         exp_fills += 2;
         ref_clear();
         ref_v[5'h03] = 1; ref_t[3] = 20'h00005;
      end
      fetch_ref(32'h0000_507C);
      fetch_ref(32'h0000_0104);

      // mixed random traffic over three aliasing tags
      for (int i = 0; i < 400; i++) begin
         logic [31:0] a;
         a = {18'd0, 2'($urandom % 3), 12'($urandom)};
         fetch_ref(a);
      end
      fe_req = 1'b0;
      repeat (20) @(negedge clk);
      chk(fills == exp_fills, "R3 final fill count", fills, exp_fills);

      if (!done) begin
         done = 1;
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end
endmodule